// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Writes

This block is a memory-mapped general-purpose I/O controller for 118 pins grouped into four banks of 32, 22, 32 and 32 pins. Global pin numbers run through the banks in order, so bank 0 holds pins 0-31, bank 1 holds 32-53, bank 2 holds 54-85 and bank 3 holds 86-117. Software reaches it over a plain 32-bit register bus with a single-cycle write strobe and a combinational read path. Every bank has direction and drive-enable controls. It also has a registered view of its pin levels and two half-word output ports. A write to one of these ports carries a 16-bit mask next to 16 data bits, so single pins change without a read-modify-write.

Each pin has interrupt detection. A pin can watch for a level or for edges: rising, falling or both. Per-pin mask bits are set through a disable port and cleared through an enable port. All unmasked events from all banks are ORed into one interrupt line.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every pin is undriven (`pin_oe` and `pin_out` all 0), `irq` is 0, every existing mask bit reads 1, and every direction bit reads 0 except bank 0 bits 7 and 8.
- R2: A write to 0x000+8*bank updates pins 0-15 of that bank. Bits 31:16 are a mask and bits 15:0 are data, and pin i takes data bit i only where mask bit i is 0.
- R3: A write to 0x004+8*bank applies the same masked rule to pins 16-31: data bit i and mask bit 16+i belong to pin 16+i.
- R4: A read of 0x060+4*bank returns the bank's pin levels, bit n being pin n. The value is the one sampled at the previous clock edge.
- R5: The direction register (0x204+0x40*bank, 1 = output) and the drive-enable register (0x208+0x40*bank) read back what was written. A pin is driven (`pin_oe`=1) only where both bits are 1, and `pin_out` carries the output value there and 0 elsewhere.
- R6: Direction bits 7 and 8 of bank 0 always read 1 and those pins stay outputs, whatever is written.
- R7: Writing 1s to 0x210+0x40*bank clears those mask bits, and writing 1s to 0x214+0x40*bank sets them. The mask at 0x20C+0x40*bank is read-only, so writing all ones to the disable port masks the whole bank.
- R8: With type bit (0x21C+0x40*bank) = 1 and any-edge bit 0, the polarity bit (0x220+0x40*bank) selects rising (1) or falling (0) edges. The status bit (0x218+0x40*bank) is sticky until a 1 is written to it.
- R9: With type 1 and any-edge bit (0x224+0x40*bank) = 1, both rising and falling edges set the status bit.
- R10: With type 0, a status bit reads 1 while the pin level equals its polarity bit, and writing 1 to it has no effect.
- R11: `irq` is 1 exactly when some bank has a status bit set whose mask bit is 0. Status is reported regardless of mask.
- R12: Bits 22-31 of every bank 1 register read 0 and ignore writes.
- R13: Bank b's bit n is global pin bank_base(b)+n, with bases 0, 32, 54 and 86.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 118 | Pin levels from the pads |
| pin_out | output | 118 | Output values, 0 where not driven |
| pin_oe | output | 118 | Drive enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
Masked writes are driven with three patterns: all mask bits clear, one byte masked, and all mask bits set. These separate a correct mask from one that is inverted or ignored. The tests target the low and high halves of different banks, including the short bank and the last bank, so an error in the bank or half-word offset shows up on the wrong global pins. Interrupts are driven by rising and falling edges under each polarity and with any-edge mode. Pin-level matches are also tried, with the mask both open and closed. These runs tell sticky edge status apart from live level status, and a raw status bit apart from an unmasked one.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

    localparam int NUM_BANKS  = 4;
    localparam int BANK_IDX_W = $clog2(NUM_BANKS);
    localparam int REG_W      = 32;
    localparam int HALF_W     = REG_W / 2;
    localparam int ADDR_W     = 12;

    // Width of each bank; bank 1 is the short one.
    function automatic int bank_width(input int b);
        return (b == 1) ? 22 : 32;
    endfunction

    // First global pin number of a bank.
    function automatic int bank_base(input int b);
        int s;
        s = 0;
        for (int i = 0; i < b; i++) s += bank_width(i);
        return s;
    endfunction

    // Direction bits that are fixed to output.
    function automatic logic [REG_W-1:0] forced_out(input int b);
        return (b == 0) ? 32'h0000_0180 : 32'h0;
    endfunction

    localparam int TOTAL_PINS = bank_base(NUM_BANKS);

    typedef enum logic [3:0] {
        RS_NONE, RS_DATA_LO, RS_DATA_HI, RS_LEVEL, RS_DIR, RS_OE,
        RS_IMASK, RS_IEN, RS_IDIS, RS_ISTS, RS_ITYPE, RS_IPOL, RS_IANY
    } reg_sel_e;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_ctrl_pkg::*;
(
    input  logic [ADDR_W-1:0]     addr,
    output reg_sel_e              sel,
    output logic [BANK_IDX_W-1:0] bank
);
    always_comb begin
        sel  = RS_NONE;
        bank = '0;
        if (addr[ADDR_W-1:5] == '0 && addr[1:0] == 2'b00) begin
            bank = addr[3 +: BANK_IDX_W];
            sel  = addr[2] ? RS_DATA_HI : RS_DATA_LO;
        end else if (addr[ADDR_W-1:4] == 8'h06 && addr[1:0] == 2'b00) begin
            bank = addr[2 +: BANK_IDX_W];
            sel  = RS_LEVEL;
        end else if (addr[ADDR_W-1:8] == 4'h2) begin
            bank = addr[6 +: BANK_IDX_W];
            unique case (addr[5:0])
                6'h04:   sel = RS_DIR;
                6'h08:   sel = RS_OE;
                6'h0C:   sel = RS_IMASK;
                6'h10:   sel = RS_IEN;
                6'h14:   sel = RS_IDIS;
                6'h18:   sel = RS_ISTS;
                6'h1C:   sel = RS_ITYPE;
                6'h20:   sel = RS_IPOL;
                6'h24:   sel = RS_IANY;
                default: sel = RS_NONE;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int REG_W = 32,
    parameter logic [REG_W-1:0] VALID = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] level,
    input  logic [REG_W-1:0] itype,
    input  logic [REG_W-1:0] ipol,
    input  logic [REG_W-1:0] iany,
    input  logic [REG_W-1:0] clr,
    output logic [REG_W-1:0] status
);
    logic [REG_W-1:0] prev_q, sticky_q;
    logic [REG_W-1:0] rise, fall, edge_hit, lvl_hit;

    always_comb begin
        rise     = level & ~prev_q;
        fall     = ~level & prev_q;
        edge_hit = itype & ((iany & (rise | fall)) |
                            (~iany & ipol & rise) |
                            (~iany & ~ipol & fall));
        lvl_hit  = ~itype & ~(level ^ ipol);
        status   = ((sticky_q & itype) | lvl_hit) & VALID;
    end

    // A new event wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            sticky_q <= '0;
        end else begin
            prev_q   <= level;
            sticky_q <= ((sticky_q & ~clr) | edge_hit) & VALID;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_ctrl_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter logic [REG_W-1:0] FORCE_OUT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [REG_W-1:0] wdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [REG_W-1:0] rdata,
    output logic             irq
);
    localparam logic [REG_W-1:0] VALID = REG_W'((64'd1 << WIDTH) - 64'd1);

    logic [REG_W-1:0] out_q, dir_q, oe_q, mask_q, type_q, pol_q, any_q, level_q;
    logic [REG_W-1:0] pin_ext, out_nx, status, clr, drive;
    logic [HALF_W-1:0] half_new_lo, half_new_hi;

    always_comb begin
        pin_ext = '0;
        pin_ext[WIDTH-1:0] = pin_in;
    end

    // Masked half-word merge: a 0 mask bit lets the data bit through.
    always_comb begin
        half_new_lo = (out_q[HALF_W-1:0] & wdata[REG_W-1:HALF_W]) |
                      (wdata[HALF_W-1:0] & ~wdata[REG_W-1:HALF_W]);
        half_new_hi = (out_q[REG_W-1:HALF_W] & wdata[REG_W-1:HALF_W]) |
                      (wdata[HALF_W-1:0] & ~wdata[REG_W-1:HALF_W]);
        out_nx = out_q;
        if (wr_en && sel == RS_DATA_LO) out_nx[HALF_W-1:0]     = half_new_lo;
        if (wr_en && sel == RS_DATA_HI) out_nx[REG_W-1:HALF_W] = half_new_hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            dir_q   <= FORCE_OUT & VALID;
            oe_q    <= '0;
            mask_q  <= VALID;
            type_q  <= '0;
            pol_q   <= '0;
            any_q   <= '0;
            level_q <= '0;
        end else begin
            level_q <= pin_ext;
            out_q   <= out_nx & VALID;
            if (wr_en) begin
                unique case (sel)
                    RS_DIR:   dir_q  <= (wdata | FORCE_OUT) & VALID;
                    RS_OE:    oe_q   <= wdata & VALID;
                    RS_IEN:   mask_q <= mask_q & ~wdata;
                    RS_IDIS:  mask_q <= (mask_q | wdata) & VALID;
                    RS_ITYPE: type_q <= wdata & VALID;
                    RS_IPOL:  pol_q  <= wdata & VALID;
                    RS_IANY:  any_q  <= wdata & VALID;
                    default:  ;
                endcase
            end
        end
    end

    assign clr = (wr_en && sel == RS_ISTS) ? wdata : '0;

    gpio_irq_unit #(.REG_W(REG_W), .VALID(VALID)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (level_q),
        .itype  (type_q),
        .ipol   (pol_q),
        .iany   (any_q),
        .clr    (clr),
        .status (status)
    );

    always_comb begin
        unique case (sel)
            RS_LEVEL: rdata = level_q;
            RS_DIR:   rdata = dir_q;
            RS_OE:    rdata = oe_q;
            RS_IMASK: rdata = mask_q;
            RS_ISTS:  rdata = status;
            RS_ITYPE: rdata = type_q;
            RS_IPOL:  rdata = pol_q;
            RS_IANY:  rdata = any_q;
            default:  rdata = '0;
        endcase
    end

    assign drive   = dir_q & oe_q;
    assign pin_oe  = drive[WIDTH-1:0];
    assign pin_out = out_q[WIDTH-1:0] & drive[WIDTH-1:0];
    assign irq     = |(status & ~mask_q);
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int DW   = REG_W,
    parameter int PINS = TOTAL_PINS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_en,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_oe,
    output logic            irq
);
    reg_sel_e              dec_sel;
    logic [BANK_IDX_W-1:0] dec_bank;
    logic [DW-1:0]         bank_rdata [NUM_BANKS];
    logic [NUM_BANKS-1:0]  bank_irq;

    gpio_addr_dec u_dec (
        .addr (bus_addr),
        .sel  (dec_sel),
        .bank (dec_bank)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam int W = bank_width(g);
        localparam int B = bank_base(g);
        gpio_bank #(.WIDTH(W), .FORCE_OUT(forced_out(g))) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_en && bus_we && dec_bank == BANK_IDX_W'(g)),
            .sel     (dec_sel),
            .wdata   (bus_wdata),
            .pin_in  (pin_in[B +: W]),
            .pin_out (pin_out[B +: W]),
            .pin_oe  (pin_oe[B +: W]),
            .rdata   (bank_rdata[g]),
            .irq     (bank_irq[g])
        );
    end

    assign bus_rdata = bank_rdata[dec_bank];
    assign irq       = |bank_irq;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
    import gpio_ctrl_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_en,
    input logic                  bus_we,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [REG_W-1:0]      bus_wdata,
    input logic [REG_W-1:0]      bus_rdata,
    input logic [TOTAL_PINS-1:0] pin_in,
    input logic [TOTAL_PINS-1:0] pin_out,
    input logic [TOTAL_PINS-1:0] pin_oe,
    input logic                  irq
);
    a_r6_forced_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 12'h204) |-> (bus_rdata[8:7] == 2'b11));

    a_r12_bank1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 12'h064 || bus_addr == 12'h244 || bus_addr == 12'h248 ||
         bus_addr == 12'h24C || bus_addr == 12'h258) |-> (bus_rdata[31:22] == 10'd0));

    a_r5_drive_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    a_r2_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == 12'h000 && bus_wdata[31:16] == 16'hFFFF)
        |=> $stable(pin_out[15:0]));

    a_r4_level_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 12'h06C && $past(rst_n)) |-> (bus_rdata == $past(pin_in[117:86])));

    a_r11_irq_known: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(irq));
endmodule

bind gpio_bank_ctrl gpio_ctrl_chk u_chk (.*);

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
    import gpio_ctrl_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  bus_en = 1'b0, bus_we = 1'b0;
    logic [ADDR_W-1:0]     bus_addr = '0;
    logic [REG_W-1:0]      bus_wdata = '0;
    logic [REG_W-1:0]      bus_rdata;
    logic [TOTAL_PINS-1:0] pin_in = '0;
    logic [TOTAL_PINS-1:0] pin_out, pin_oe;
    logic                  irq;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    gpio_bank_ctrl u0 (.*);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_en = 1'b1; bus_we = 1'b0;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 pin_oe low", pin_oe[31:0], 32'h0);
        chk("R1 pin_out low", pin_out[117:86], 32'h0);
        chk("R1 irq low", {31'd0, irq}, 32'h0);
        rd(12'h20C, v); chk("R1 bank0 mask", v, 32'hFFFF_FFFF);
        rd(12'h24C, v); chk("R1 R12 bank1 mask", v, 32'h003F_FFFF);
        rd(12'h204, v); chk("R1 bank0 dir", v, 32'h0000_0180);
        rd(12'h244, v); chk("R1 bank1 dir", v, 32'h0);
    endtask

    task automatic t_masked();
        wr(12'h204, 32'hFFFF_FFFF); wr(12'h208, 32'hFFFF_FFFF);
        chk("R5 bank0 driven", pin_oe[31:0], 32'hFFFF_FFFF);
        wr(12'h000, 32'h0000_A5A5);
        chk("R2 open mask", {16'd0, pin_out[15:0]}, 32'h0000_A5A5);
        wr(12'h000, 32'hFF00_0000);
        chk("R2 high byte masked", {16'd0, pin_out[15:0]}, 32'h0000_A500);
        wr(12'h000, 32'hFFFF_0000);
        chk("R2 all masked", {16'd0, pin_out[15:0]}, 32'h0000_A500);
        wr(12'h004, 32'h0000_1234);
        chk("R3 bank0 high half", {16'd0, pin_out[31:16]}, 32'h0000_1234);
        chk("R3 low half untouched", {16'd0, pin_out[15:0]}, 32'h0000_A500);
    endtask

    task automatic t_banks();
        logic [31:0] v;
        wr(12'h2C4, 32'hFFFF_FFFF); wr(12'h2C8, 32'hFFFF_FFFF);
        wr(12'h01C, 32'h0000_BEEF);
        chk("R13 R3 bank3 high pins", {16'd0, pin_out[117:102]}, 32'h0000_BEEF);
        wr(12'h244, 32'hFFFF_FFFF); wr(12'h248, 32'hFFFF_FFFF);
        rd(12'h244, v); chk("R12 bank1 dir", v, 32'h003F_FFFF);
        chk("R13 bank1 drive", {10'd0, pin_oe[53:32]}, 32'h003F_FFFF);
        wr(12'h00C, 32'h0000_FFFF);
        chk("R12 R13 bank1 high", {10'd0, pin_out[53:32]}, 32'h003F_0000);
        wr(12'h25C, 32'hFFFF_FFFF);
        rd(12'h25C, v); chk("R12 bank1 type", v, 32'h003F_FFFF);
        wr(12'h25C, 32'h0);
        wr(12'h284, 32'h0000_FFFF); wr(12'h288, 32'h0);
        wr(12'h010, 32'h0000_FFFF);
        chk("R5 dir without enable", {16'd0, pin_out[69:54]}, 32'h0);
        chk("R5 no drive", pin_oe[85:54], 32'h0);
        rd(12'h284, v); chk("R5 dir readback", v, 32'h0000_FFFF);
    endtask

    task automatic t_forced();
        logic [31:0] v;
        wr(12'h204, 32'h0);
        rd(12'h204, v); chk("R6 forced readback", v, 32'h0000_0180);
        chk("R6 forced pins driven", pin_oe[31:0], 32'h0000_0180);
    endtask

    task automatic t_level();
        logic [31:0] v;
        pin_in[53:32] = 22'h2A_5A5A;
        pin_in[31:0]  = 32'hC3C3_0001;
        cyc(2);
        rd(12'h064, v); chk("R4 R12 bank1 levels", v, 32'h002A_5A5A);
        rd(12'h060, v); chk("R4 bank0 levels", v, 32'hC3C3_0001);
        pin_in[53:0] = '0;
        cyc(2);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr(12'h29C, 32'h1); wr(12'h2A0, 32'h1);
        wr(12'h298, 32'hFFFF_FFFF);
        wr(12'h290, 32'h1);
        rd(12'h28C, v); chk("R7 enable clears bit", v, 32'hFFFF_FFFE);
        chk("R11 no event", {31'd0, irq}, 32'h0);
        pin_in[54] = 1'b1; cyc(3);
        rd(12'h298, v); chk("R8 rising sets", v & 32'h1, 32'h1);
        chk("R11 irq on unmasked", {31'd0, irq}, 32'h1);
        pin_in[54] = 1'b0; cyc(3);
        rd(12'h298, v); chk("R8 sticky", v & 32'h1, 32'h1);
        wr(12'h298, 32'h1);
        rd(12'h298, v); chk("R8 w1c", v & 32'h1, 32'h0);
        chk("R11 irq clears", {31'd0, irq}, 32'h0);
        wr(12'h2A0, 32'h0);
        pin_in[54] = 1'b1; cyc(3);
        rd(12'h298, v); chk("R8 falling mode ignores rise", v & 32'h1, 32'h0);
        pin_in[54] = 1'b0; cyc(3);
        rd(12'h298, v); chk("R8 falling sets", v & 32'h1, 32'h1);
        wr(12'h298, 32'h1);
        wr(12'h2A4, 32'h1);
        pin_in[54] = 1'b1; cyc(3);
        rd(12'h298, v); chk("R9 any rise", v & 32'h1, 32'h1);
        wr(12'h298, 32'h1);
        pin_in[54] = 1'b0; cyc(3);
        rd(12'h298, v); chk("R9 any fall", v & 32'h1, 32'h1);
        wr(12'h294, 32'hFFFF_FFFF);
        rd(12'h28C, v); chk("R7 disable all", v, 32'hFFFF_FFFF);
        wr(12'h28C, 32'h0);
        rd(12'h28C, v); chk("R7 mask read-only", v, 32'hFFFF_FFFF);
        chk("R11 masked status", {31'd0, irq}, 32'h0);
        rd(12'h298, v); chk("R11 status kept when masked", v & 32'h1, 32'h1);
        wr(12'h298, 32'h1);
    endtask

    task automatic t_level_irq();
        logic [31:0] v;
        wr(12'h2E0, 32'h0000_0020);
        cyc(2);
        rd(12'h2D8, v); chk("R10 no match", v & 32'h20, 32'h0);
        pin_in[91] = 1'b1; cyc(2);
        rd(12'h2D8, v); chk("R10 high match", v & 32'h20, 32'h20);
        wr(12'h2D8, 32'h20);
        rd(12'h2D8, v); chk("R10 not clearable", v & 32'h20, 32'h20);
        chk("R11 still masked", {31'd0, irq}, 32'h0);
        wr(12'h2D0, 32'h20);
        chk("R11 level irq", {31'd0, irq}, 32'h1);
        pin_in[91] = 1'b0; cyc(2);
        chk("R10 irq follows level", {31'd0, irq}, 32'h0);
        wr(12'h2D4, 32'hFFFF_FFFF);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_masked();
        t_banks();
        t_forced();
        t_level();
        t_edge();
        t_level_irq();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule